// File: doc/BRIEF.md
# Folded Multiply-Accumulate FIR Filter

This block is a finite impulse response filter that computes all of its taps with one multiplier. Its clock runs at least TAPS times faster than the input samples arrive. Each accepted sample starts a sweep of TAPS cycles. In every cycle of the sweep, one counter picks a coefficient index and the delayed sample that belongs to that index. The product goes into a full-precision accumulator. When the sweep ends, the finished sum is presented together with a one-cycle valid pulse.

Input samples enter a shift-register history. Index 0 holds the newest accepted sample and index k holds the sample accepted k samples earlier. A registered multiplexer taps this history, and a coefficient store with synchronous read supplies the weights. Both are addressed by the same sweep counter. The multiplexer output is registered once so that it arrives at the multiplier together with the coefficient read, which has one cycle of latency.

Coefficients can be rewritten at any time while the filter runs. Writes land in a staging copy. Each new sweep takes a snapshot of that copy when it starts, so a sweep never mixes old and new weights. A sample that arrives before the running sweep can hand over is refused, and the refusal is flagged.

Top module: `fir_fold`

## Requirements
- R1: After reset, out_valid, overrun and out_data are all zero. The sample history and every coefficient are also zero: the output for the first sample is zero until a coefficient is written, and earlier history counts as zero.
- R2: For each accepted sample n, the output is the sum over k = 0..TAPS-1 of coefficient[k] * x[n-k]. Both operands are signed two's complement. Index k = 0 pairs with the sample just accepted, and k pairs with the sample accepted k acceptances earlier.
- R3: out_valid is high for exactly one cycle for each accepted sample. It rises on the 17th rising edge after the accepting edge (TAPS + 1 edges later).
- R4: A new sample is accepted when in_valid is high on the edge 16 cycles (TAPS) after the previous accepting edge. It is also accepted on any later edge. This gives a throughput of one sample per TAPS cycles.
- R5: When in_valid is high on any of the TAPS-1 edges that follow an accepting edge, the sample is refused. The history is not changed, and overrun is high for the one cycle after that edge.
- R6: A coefficient write uses cw_en = 1, cw_addr = k (the tap index of R2) and cw_data. A sweep uses exactly the writes made on edges before its accepting edge. A write on the accepting edge, or during the sweep, first applies to the next sweep.
- R7: out_data is ACC_W = DATA_W + COEF_W + log2(TAPS) bits wide and carries the exact signed sum with no overflow. This holds even when every sample and every coefficient equals the most negative value.
- R8: out_data keeps its last value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | log2(TAPS) | Coefficient tap index |
| cw_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | One-cycle pulse marking a finished sum |
| out_data | output | ACC_W | Signed filter output |
| overrun | output | 1 | Pulse after a refused sample |

## Verification
A fault in the sweep counter or its tags shows up as a wrong sum, or as a valid pulse in the wrong cycle, at the first output after the fault. If the sample select drifts by one index against the coefficient read, every output becomes a sum of misaligned products. An impulse makes this visible at once, because the impulse response comes out shifted. A history that shifts on a refused sample, or a coefficient snapshot taken at the wrong moment, corrupts the next sum after the overrun or the mid-stream reload. A wrong guard width shows only under the extreme-value pattern.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;
   // Per-cycle tag that travels alongside the selected tap.
   typedef struct packed {
      logic live;   // a tap of a sweep is in this stage
      logic head;   // first tap of the sweep
      logic tail;   // last tap of the sweep
   } sweep_tag_t;
endpackage

// File: rtl/fold_sweep_ctrl.sv
module fold_sweep_ctrl
   import fir_fold_pkg::*;
#(
   parameter int TAPS = 16,
   localparam int IDX_W = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   output logic             accept,
   output logic             overrun,
   output logic [IDX_W-1:0] tap_sel,
   output sweep_tag_t       tag
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS - 1);

   logic             live;
   logic [IDX_W-1:0] cnt;
   logic             at_tail;

   assign at_tail = (cnt == LAST);
   // Hand-over on the last tap keeps one sample per TAPS cycles.
   assign accept  = start_req & (~live | at_tail);
   assign tap_sel = cnt;

   always_comb begin
      tag.live = live;
      tag.head = live & (cnt == '0);
      tag.tail = live & at_tail;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live    <= 1'b0;
         cnt     <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= start_req & live & ~at_tail;
         if (accept) begin
            live <= 1'b1;
            cnt  <= '0;
         end else if (live) begin
            if (at_tail) live <= 1'b0;
            else         cnt  <= cnt + IDX_W'(1);
         end
      end
   end

   // R4
   sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (live && cnt == '0));

   // R3
   tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !at_tail) |=> (live && cnt == $past(cnt) + IDX_W'(1)));

   // R5
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && live && !at_tail) |=> overrun);
endmodule

// File: rtl/fold_tap_line.sv
module fold_tap_line #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 16,
   localparam int IDX_W = $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]  sel,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] stage [TAPS];

   for (genvar g = 0; g < TAPS; g++) begin : g_stage
      logic [DATA_W-1:0] feed;
      if (g == 0) begin : g_head
         assign feed = din;
      end else begin : g_body
         assign feed = stage[g-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)        stage[g] <= '0;
         else if (shift_en) stage[g] <= feed;
      end
   end

   // Registered select: matches the coefficient read latency.
   always_ff @(posedge clk) begin
      if (!rst_n) dout <= '0;
      else        dout <= stage[sel];
   end

   // R2
   tap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (stage[0] == $past(din)));

   // R5
   tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(stage[TAPS-1]));
endmodule

// File: rtl/fold_coef_store.sv
module fold_coef_store #(
   parameter int COEF_W = 16,
   parameter int TAPS   = 16,
   localparam int IDX_W = $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [COEF_W-1:0] wdata,
   input  logic              load,
   input  logic [IDX_W-1:0]  raddr,
   output logic [COEF_W-1:0] rdata
);
   logic [COEF_W-1:0] staging [TAPS];
   logic [COEF_W-1:0] active  [TAPS];

   for (genvar g = 0; g < TAPS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            staging[g] <= '0;
            active[g]  <= '0;
         end else begin
            if (we && waddr == IDX_W'(g)) staging[g] <= wdata;
            if (load)                     active[g]  <= staging[g];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= active[raddr];
   end

   // R6
   stage_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (staging[$past(waddr)] == $past(wdata)));

   // R6
   snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (active[TAPS-1] == $past(staging[TAPS-1])));
endmodule

// File: rtl/fold_mac.sv
module fold_mac
   import fir_fold_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int ACC_W  = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] samp,
   input  logic [COEF_W-1:0] coef,
   input  sweep_tag_t        tag,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_data
);
   localparam int PROD_W = DATA_W + COEF_W;

   logic signed [DATA_W-1:0] samp_s;
   logic signed [COEF_W-1:0] coef_s;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_x;
   logic signed [ACC_W-1:0]  acc;
   logic signed [ACC_W-1:0]  acc_nxt;
   logic signed [ACC_W:0]    acc_wide;

   assign samp_s   = $signed(samp);
   assign coef_s   = $signed(coef);
   assign prod     = samp_s * coef_s;
   assign prod_x   = ACC_W'(prod);
   assign acc_nxt  = tag.head ? prod_x : acc + prod_x;
   assign acc_wide = (ACC_W + 1)'(acc) + (ACC_W + 1)'(prod_x);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= tag.live & tag.tail;
         if (tag.live)             acc      <= acc_nxt;
         if (tag.live && tag.tail) out_data <= acc_nxt;
      end
   end

   // R3
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag.live && !tag.head) |-> (acc_wide[ACC_W] == acc_wide[ACC_W-1]));
endmodule

// File: rtl/fir_fold.sv
module fir_fold
   import fir_fold_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int TAPS   = 16,
   localparam int IDX_W = $clog2(TAPS),
   localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cw_en,
   input  logic [IDX_W-1:0]  cw_addr,
   input  logic [COEF_W-1:0] cw_data,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_data,
   output logic              overrun
);
   if (TAPS < 2) begin : g_bad_taps
      $error("fir_fold: TAPS must be at least 2");
   end
   if ((1 << IDX_W) != TAPS) begin : g_bad_pow2
      $error("fir_fold: TAPS must be a power of two");
   end
   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("fir_fold: operand widths must be at least 2");
   end

   logic              accept;
   logic [IDX_W-1:0]  tap_sel;
   sweep_tag_t        tag_c;
   sweep_tag_t        tag_q;
   logic [DATA_W-1:0] samp_q;
   logic [COEF_W-1:0] coef_q;

   fold_sweep_ctrl #(.TAPS(TAPS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (in_valid),
      .accept    (accept),
      .overrun   (overrun),
      .tap_sel   (tap_sel),
      .tag       (tag_c)
   );

   fold_tap_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_taps (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (accept),
      .din      (in_data),
      .sel      (tap_sel),
      .dout     (samp_q)
   );

   fold_coef_store #(.COEF_W(COEF_W), .TAPS(TAPS)) u_coef (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cw_en),
      .waddr (cw_addr),
      .wdata (cw_data),
      .load  (accept),
      .raddr (tap_sel),
      .rdata (coef_q)
   );

   // Tag follows the select through the same single register stage.
   always_ff @(posedge clk) begin
      if (!rst_n) tag_q <= '0;
      else        tag_q <= tag_c;
   end

   fold_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp      (samp_q),
      .coef      (coef_q),
      .tag       (tag_q),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // R3
   tail_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_c.tail |=> ##1 out_valid);
endmodule

// File: tb/fir_fold_bench.sv
module fir_fold_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 16;
   localparam int COEF_W = 16;
   localparam int TAPS   = 16;
   localparam int IDX_W  = $clog2(TAPS);
   localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS);
   localparam int LAT    = TAPS + 2;
   localparam int WATCHDOG = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              cw_en = 1'b0;
   logic [IDX_W-1:0]  cw_addr = '0;
   logic [COEF_W-1:0] cw_data = '0;
   logic              out_valid;
   logic [ACC_W-1:0]  out_data;
   logic              overrun;

   fir_fold u_fir_fold (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
      .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int     errors = 0;
   int     checks = 0;
   int     cyc = 0;
   bit     done = 1'b0;
   int     coef_m [TAPS];
   int     hist   [TAPS];
   longint exp_v [$];
   int     exp_t [$];
   longint last_out = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic longint ref_fir();
      longint s = 0;
      for (int k = 0; k < TAPS; k++) s += longint'(coef_m[k]) * longint'(hist[k]);
      return s;
   endfunction

   function automatic int rnd16();
      logic [15:0] r;
      r = 16'($urandom);
      return int'($signed(r));
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Accepted sample: model history, queue expected sum and cycle.
   task automatic push_expect(input int x);
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp_v.push_back(ref_fir());
      exp_t.push_back(cyc + LAT);
   endtask

   task automatic send(input int x);
      in_valid = 1'b1;
      in_data  = DATA_W'(x);
      push_expect(x);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      cw_en   = 1'b1;
      cw_addr = IDX_W'(a);
      cw_data = COEF_W'(d);
      @(negedge clk);
      cw_en = 1'b0;
      coef_m[a] = int'($signed(COEF_W'(d)));
   endtask

   // R6: write on the accepting edge belongs to the next sweep.
   task automatic send_wr(input int x, input int a, input int d);
      cw_en   = 1'b1;
      cw_addr = IDX_W'(a);
      cw_data = COEF_W'(d);
      in_valid = 1'b1;
      in_data  = DATA_W'(x);
      push_expect(x);
      @(negedge clk);
      in_valid = 1'b0;
      cw_en    = 1'b0;
      coef_m[a] = int'($signed(COEF_W'(d)));
   endtask

   // R5: refused sample, overrun expected on the following cycle.
   task automatic poke(input int x);
      chk(overrun == 1'b0, "R5 overrun idle", longint'(overrun), 0);
      in_valid = 1'b1;
      in_data  = DATA_W'(x);
      @(negedge clk);
      in_valid = 1'b0;
      chk(overrun == 1'b1, "R5 overrun pulse", longint'(overrun), 1);
   endtask

   // Output monitor: value (R2), timing (R3), hold (R8).
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_v.size() == 0) begin
               chk(1'b0, "R3 unexpected pulse", 1, 0);
            end else begin
               longint ev;
               int     et;
               ev = exp_v.pop_front();
               et = exp_t.pop_front();
               chk(longint'($signed(out_data)) == ev, "R2 sum",
                   longint'($signed(out_data)), ev);
               chk(cyc == et, "R3 pulse cycle", longint'(cyc), longint'(et));
               last_out = longint'($signed(out_data));
            end
         end else begin
            chk(longint'($signed(out_data)) == last_out, "R8 hold",
                longint'($signed(out_data)), last_out);
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=finish", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7391));
      for (int k = 0; k < TAPS; k++) begin
         coef_m[k] = 0;
         hist[k]   = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
      chk(overrun == 1'b0, "R1 overrun", longint'(overrun), 0);
      chk(out_data == '0, "R1 out_data", longint'($signed(out_data)), 0);

      // R1: coefficients start at zero
      send(1234);
      idle(LAT);

      // Impulse (R2): history of zeros plus one sample
      for (int k = 0; k < TAPS; k++) wr(k, k + 1);
      send(0);
      idle(TAPS + 2);
      send(1000);
      idle(TAPS + 1);
      for (int i = 0; i < TAPS + 2; i++) begin
         send(0);
         idle(TAPS + 1);
      end

      // Step, back-to-back at the minimum interval (R4)
      for (int i = 0; i < TAPS + 4; i++) begin
         send(500);
         idle(TAPS - 1);
      end
      idle(LAT);

      // R5 refusal inside a sweep, then boundary hand-over (R4)
      send(77);
      idle(4);
      poke(-9999);
      idle(10);
      send(-300);
      idle(TAPS - 2);
      poke(31000);
      send(42);
      idle(LAT);

      // Random coefficients and samples
      for (int k = 0; k < TAPS; k++) wr(k, rnd16());
      for (int i = 0; i < 40; i++) begin
         send(rnd16());
         idle(TAPS - 1 + int'($urandom % 5));
      end

      // R6 mid-stream reload: during sweep, at accept, before accept
      send(rnd16());
      idle(3);
      wr(3, rnd16());
      wr(0, -5);
      idle(TAPS - 3);
      send_wr(rnd16(), 7, rnd16());
      idle(TAPS - 2);
      wr(15, 12345);
      send(rnd16());
      idle(TAPS - 1);
      for (int i = 0; i < 6; i++) begin
         send(rnd16());
         idle(TAPS - 1);
      end
      idle(LAT);

      // R7 extreme magnitudes
      for (int k = 0; k < TAPS; k++) wr(k, -32768);
      for (int i = 0; i < TAPS; i++) begin
         send(-32768);
         idle(TAPS - 1);
      end
      for (int k = 0; k < TAPS; k++) wr(k, 32767);
      for (int i = 0; i < TAPS; i++) begin
         send(-32768);
         idle(TAPS - 1);
      end
      idle(LAT + 4);

      chk(exp_v.size() == 0, "R3 all outputs seen", longint'(exp_v.size()), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule